// File: doc/BRIEF.md
# Event-to-task shortcut and interrupt unit

This unit sits between a two-wire bus master engine and the software that drives it. The engine reports what it is doing through single-cycle event pulses: stopped, error, suspended, receive-started, transmit-started, last-receive and last-transmit. The unit latches each pulse into a sticky flag. It keeps a mask of interrupt enables and drives one interrupt line whenever an enabled flag is set. It also latches the error causes the engine reports: address not acknowledged, data not acknowledged, and receive overrun.

Software starts, stops, suspends and resumes the engine with task pulses. The unit forwards these pulses to the engine. A shortcut register can also turn chosen events straight into task pulses in the same cycle. With it, sequences such as "write two bytes, then repeated START, then read four bytes, then stop" run without software stepping in. The unit also enforces two rules on the task outputs:

- A stop requested while the engine is suspended is held back and released just after the resume.
- A start request is dropped while a transfer is already in flight.

Top module: `i2cm_event_ctl`

## Requirements
- R1: After reset, the event flags, interrupt enables, shortcut bits and error bits are all 0. The interrupt line is low, and no task output pulses while no input is active.
- R2: An event pulse on ev_i bit k sets flag k from the next cycle. The flag stays set until software writes a 0 to bit k at address 4; writing a 1 there leaves it as it is. If an event and a clearing write land in the same cycle, the flag ends up set. The event bit order is: 0 stopped, 1 error, 2 suspended, 3 receive-started, 4 transmit-started, 5 last-receive, 6 last-transmit.
- R3: The interrupt enables are written directly at address 1. At address 2, each data bit that is 1 sets the matching enable. At address 3, each data bit that is 1 clears the matching enable. int_en_o always shows the current enables.
- R4: irq_o is high exactly when some flag and its matching enable are both 1. It therefore rises in the cycle after the event pulse.
- R5: The shortcut bits are written at address 0, using bits 4:0. The mapping is:
  - bit 0: last-transmit starts a receive
  - bit 1: last-transmit suspends
  - bit 2: last-transmit stops
  - bit 3: last-receive starts a transmit
  - bit 4: last-receive stops

  An enabled shortcut pulses its task output in the same cycle as its source event. A disabled shortcut produces no pulse.
- R6: Software task inputs reach their task outputs in the same cycle, ORed with the shortcut pulses.
- R7: The engine counts as suspended from a suspend task output until a resume task output. A stop requested in that window gives no stop pulse while suspended. Instead, exactly one stop pulse follows, one cycle after the resume pulse.
- R8: The unit counts as busy from a start task output until a stopped, last-receive or last-transmit event. A start request while busy is dropped. A start request in the same cycle as one of those events is passed on, so a start from a shortcut after a last event makes a repeated START.
- R9: Error pulses set sticky error bits: overrun sets bit 0, address NACK sets bit 1, data NACK sets bit 2. A write at address 5 clears bit 1 or bit 2 wherever the data bit is 1, and loads bit 0 directly from data bit 0.
- R10: With shortcuts 0 and 4 enabled, a write of two bytes followed by a read of four bytes runs like this:
  - A software start-transmit begins it.
  - The receive starts in the same cycle as last-transmit.
  - The stop comes in the same cycle as last-receive.
  - No other task pulses occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 7 | Engine event pulses (bit order in R2) |
| err_ovr_i | input | 1 | Engine overrun pulse |
| err_anack_i | input | 1 | Engine address-NACK pulse |
| err_dnack_i | input | 1 | Engine data-NACK pulse |
| sw_start_tx_i | input | 1 | Software start-transmit task |
| sw_start_rx_i | input | 1 | Software start-receive task |
| sw_stop_i | input | 1 | Software stop task |
| sw_suspend_i | input | 1 | Software suspend task |
| sw_resume_i | input | 1 | Software resume task |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 7 | Register write data |
| task_start_tx_o | output | 1 | Start-transmit pulse to engine |
| task_start_rx_o | output | 1 | Start-receive pulse to engine |
| task_stop_o | output | 1 | Stop pulse to engine |
| task_suspend_o | output | 1 | Suspend pulse to engine |
| task_resume_o | output | 1 | Resume pulse to engine |
| evt_flags_o | output | 7 | Sticky event flags |
| int_en_o | output | 7 | Interrupt enables |
| shorts_o | output | 5 | Shortcut enables |
| err_src_o | output | 3 | Error source bits |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench builds the unit with its default widths: seven events, five shortcuts and three error bits. At that size, every pairing of one set flag with one enabled interrupt can be swept, 49 cases in all. Every shortcut is also tried both enabled and disabled, with the full task vector compared against the expected one. The small widths also leave room for the hand-timed sequences:

- the held stop across a suspend,
- the dropped start while busy,
- the automatic write-then-read-then-stop chain.

// File: rtl/i2cm_event_pkg.sv
package i2cm_event_pkg;
    localparam int EV_W  = 7;
    localparam int SC_W  = 5;
    localparam int ERR_W = 3;
    localparam int AD_W  = 3;
    localparam int WD_W  = EV_W;

    // event bit positions
    localparam int EV_STOPPED   = 0;
    localparam int EV_ERROR     = 1;
    localparam int EV_SUSPENDED = 2;
    localparam int EV_RXSTART   = 3;
    localparam int EV_TXSTART   = 4;
    localparam int EV_LASTRX    = 5;
    localparam int EV_LASTTX    = 6;

    // shortcut bit positions
    localparam int SC_LTX_RX   = 0;
    localparam int SC_LTX_SUSP = 1;
    localparam int SC_LTX_STOP = 2;
    localparam int SC_LRX_TX   = 3;
    localparam int SC_LRX_STOP = 4;

    // register write addresses
    localparam logic [AD_W-1:0] A_SHORTS = 3'd0;
    localparam logic [AD_W-1:0] A_INTEN  = 3'd1;
    localparam logic [AD_W-1:0] A_INTSET = 3'd2;
    localparam logic [AD_W-1:0] A_INTCLR = 3'd3;
    localparam logic [AD_W-1:0] A_EVFLAG = 3'd4;
    localparam logic [AD_W-1:0] A_ERRSRC = 3'd5;
endpackage

// File: rtl/i2cm_evt_irq.sv
module i2cm_evt_irq
    import i2cm_event_pkg::*;
#(
    parameter int N_EV = EV_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev_i,
    input  logic            wr_en_i,
    input  logic [AD_W-1:0] wr_addr_i,
    input  logic [N_EV-1:0] wr_data_i,
    output logic [N_EV-1:0] flags_o,
    output logic [N_EV-1:0] en_o,
    output logic            irq_o
);
    typedef struct packed {
        logic [N_EV-1:0] flags;
        logic [N_EV-1:0] en;
    } irq_st_t;

    irq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (wr_addr_i)
                A_EVFLAG: st_d.flags = st_q.flags & wr_data_i;
                A_INTEN:  st_d.en    = wr_data_i;
                A_INTSET: st_d.en    = st_q.en | wr_data_i;
                A_INTCLR: st_d.en    = st_q.en & ~wr_data_i;
                default:  ;
            endcase
        end
        // an arriving event wins over a clearing write
        st_d.flags = st_d.flags | ev_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags_o = st_q.flags;
    assign en_o    = st_q.en;
    assign irq_o   = |(st_q.flags & st_q.en);

    for (genvar k = 0; k < N_EV; k++) begin : g_chk
        // R2: an event always leaves its flag set
        a_r2_flag_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
            ev_i[k] |=> flags_o[k]);
        // R3: a set-port write always leaves the enable on
        a_r3_set_port: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en_i && wr_addr_i == A_INTSET && wr_data_i[k]) |=> en_o[k]);
    end
endmodule

// File: rtl/i2cm_err_src.sv
module i2cm_err_src
    import i2cm_event_pkg::*;
#(
    parameter int N_ERR = ERR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ovr_i,
    input  logic             anack_i,
    input  logic             dnack_i,
    input  logic             wr_en_i,
    input  logic [AD_W-1:0]  wr_addr_i,
    input  logic [N_ERR-1:0] wr_data_i,
    output logic [N_ERR-1:0] err_o
);
    typedef struct packed {
        logic dnack;
        logic anack;
        logic ovr;
    } err_st_t;

    err_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i && wr_addr_i == A_ERRSRC) begin
            st_d.ovr   = wr_data_i[0];
            st_d.anack = st_q.anack & ~wr_data_i[1];
            st_d.dnack = st_q.dnack & ~wr_data_i[2];
        end
        st_d.ovr   = st_d.ovr   | ovr_i;
        st_d.anack = st_d.anack | anack_i;
        st_d.dnack = st_d.dnack | dnack_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = {st_q.dnack, st_q.anack, st_q.ovr};

    // R9: a NACK pulse is always recorded
    a_r9_anack_latched: assert property (@(posedge clk) disable iff (!rst_n)
        anack_i |=> err_o[1]);
    a_r9_dnack_latched: assert property (@(posedge clk) disable iff (!rst_n)
        dnack_i |=> err_o[2]);
endmodule

// File: rtl/i2cm_task_route.sv
module i2cm_task_route
    import i2cm_event_pkg::*;
#(
    parameter int N_SC = SC_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ev_stopped_i,
    input  logic            ev_lastrx_i,
    input  logic            ev_lasttx_i,
    input  logic            sw_start_tx_i,
    input  logic            sw_start_rx_i,
    input  logic            sw_stop_i,
    input  logic            sw_suspend_i,
    input  logic            sw_resume_i,
    input  logic            wr_en_i,
    input  logic [AD_W-1:0] wr_addr_i,
    input  logic [N_SC-1:0] wr_data_i,
    output logic [N_SC-1:0] shorts_o,
    output logic            task_start_tx_o,
    output logic            task_start_rx_o,
    output logic            task_stop_o,
    output logic            task_suspend_o,
    output logic            task_resume_o
);
    typedef struct packed {
        logic [N_SC-1:0] shorts;
        logic            busy;
        logic            susp;
        logic            stop_pend;
    } rt_st_t;

    rt_st_t st_d, st_q;

    logic end_ev, start_ok, stop_req, tx_req, rx_req;

    always_comb begin
        end_ev   = ev_stopped_i | ev_lastrx_i | ev_lasttx_i;
        start_ok = ~st_q.busy | end_ev;
        tx_req   = sw_start_tx_i | (ev_lastrx_i & st_q.shorts[SC_LRX_TX]);
        rx_req   = sw_start_rx_i | (ev_lasttx_i & st_q.shorts[SC_LTX_RX]);
        stop_req = sw_stop_i
                 | (ev_lasttx_i & st_q.shorts[SC_LTX_STOP])
                 | (ev_lastrx_i & st_q.shorts[SC_LRX_STOP]);

        task_start_tx_o = tx_req & start_ok;
        task_start_rx_o = rx_req & start_ok;
        task_suspend_o  = sw_suspend_i | (ev_lasttx_i & st_q.shorts[SC_LTX_SUSP]);
        task_resume_o   = sw_resume_i;
        task_stop_o     = (stop_req | st_q.stop_pend) & ~st_q.susp;

        st_d = st_q;
        if (wr_en_i && wr_addr_i == A_SHORTS) st_d.shorts = wr_data_i;
        st_d.busy      = (st_q.busy & ~end_ev) | task_start_tx_o | task_start_rx_o;
        st_d.susp      = (st_q.susp | task_suspend_o) & ~task_resume_o;
        st_d.stop_pend = (st_q.stop_pend | stop_req) & st_q.susp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign shorts_o = st_q.shorts;

    // R7: a held stop is released right after the suspension ends
    a_r7_stop_released: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stop_pend && $fell(st_q.susp)) |-> task_stop_o);
    // R8: no start reaches the engine during a transfer in flight
    a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !end_ev) |-> !(task_start_tx_o || task_start_rx_o));
    // R5: last-transmit with its shortcut gives a repeated START
    a_r5_ltx_to_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_lasttx_i && st_q.shorts[SC_LTX_RX]) |-> task_start_rx_o);
endmodule

// File: rtl/i2cm_event_ctl.sv
module i2cm_event_ctl
    import i2cm_event_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EV_W-1:0]  ev_i,
    input  logic             err_ovr_i,
    input  logic             err_anack_i,
    input  logic             err_dnack_i,
    input  logic             sw_start_tx_i,
    input  logic             sw_start_rx_i,
    input  logic             sw_stop_i,
    input  logic             sw_suspend_i,
    input  logic             sw_resume_i,
    input  logic             wr_en_i,
    input  logic [AD_W-1:0]  wr_addr_i,
    input  logic [WD_W-1:0]  wr_data_i,
    output logic             task_start_tx_o,
    output logic             task_start_rx_o,
    output logic             task_stop_o,
    output logic             task_suspend_o,
    output logic             task_resume_o,
    output logic [EV_W-1:0]  evt_flags_o,
    output logic [EV_W-1:0]  int_en_o,
    output logic [SC_W-1:0]  shorts_o,
    output logic [ERR_W-1:0] err_src_o,
    output logic             irq_o
);
    i2cm_evt_irq #(.N_EV(EV_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev_i      (ev_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .flags_o   (evt_flags_o),
        .en_o      (int_en_o),
        .irq_o     (irq_o)
    );

    i2cm_err_src #(.N_ERR(ERR_W)) u_err (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_i     (err_ovr_i),
        .anack_i   (err_anack_i),
        .dnack_i   (err_dnack_i),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i[ERR_W-1:0]),
        .err_o     (err_src_o)
    );

    i2cm_task_route #(.N_SC(SC_W)) u_route (
        .clk             (clk),
        .rst_n           (rst_n),
        .ev_stopped_i    (ev_i[EV_STOPPED]),
        .ev_lastrx_i     (ev_i[EV_LASTRX]),
        .ev_lasttx_i     (ev_i[EV_LASTTX]),
        .sw_start_tx_i   (sw_start_tx_i),
        .sw_start_rx_i   (sw_start_rx_i),
        .sw_stop_i       (sw_stop_i),
        .sw_suspend_i    (sw_suspend_i),
        .sw_resume_i     (sw_resume_i),
        .wr_en_i         (wr_en_i),
        .wr_addr_i       (wr_addr_i),
        .wr_data_i       (wr_data_i[SC_W-1:0]),
        .shorts_o        (shorts_o),
        .task_start_tx_o (task_start_tx_o),
        .task_start_rx_o (task_start_rx_o),
        .task_stop_o     (task_stop_o),
        .task_suspend_o  (task_suspend_o),
        .task_resume_o   (task_resume_o)
    );
endmodule

// File: tb/i2cm_event_ctl_test.sv
`timescale 1ns/1ps
module i2cm_event_ctl_test;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [6:0] ev = 0;
    logic       ovr = 0, anack = 0, dnack = 0;
    logic       s_tx = 0, s_rx = 0, s_stop = 0, s_susp = 0, s_res = 0;
    logic       wr = 0;
    logic [2:0] addr = 0;
    logic [6:0] wdata = 0;
    logic       t_tx, t_rx, t_stop, t_susp, t_res;
    logic [6:0] flags, en;
    logic [4:0] shorts;
    logic [2:0] err;
    logic       irq;
    int         n_tests = 0, n_fail = 0;

    always #5 clk = ~clk;

    i2cm_event_ctl uut (
        .clk(clk), .rst_n(rst_n), .ev_i(ev),
        .err_ovr_i(ovr), .err_anack_i(anack), .err_dnack_i(dnack),
        .sw_start_tx_i(s_tx), .sw_start_rx_i(s_rx), .sw_stop_i(s_stop),
        .sw_suspend_i(s_susp), .sw_resume_i(s_res),
        .wr_en_i(wr), .wr_addr_i(addr), .wr_data_i(wdata),
        .task_start_tx_o(t_tx), .task_start_rx_o(t_rx), .task_stop_o(t_stop),
        .task_suspend_o(t_susp), .task_resume_o(t_res),
        .evt_flags_o(flags), .int_en_o(en), .shorts_o(shorts),
        .err_src_o(err), .irq_o(irq)
    );

    function automatic logic [4:0] tasks();
        return {t_res, t_susp, t_stop, t_rx, t_tx};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wreg(input logic [2:0] a, input logic [6:0] d);
        wr = 1; addr = a; wdata = d;
        cyc();
        wr = 0; wdata = 0;
    endtask

    task automatic pulse_ev(input int k);
        ev = 7'(1 << k);
        cyc();
        ev = 0;
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        chk("R1 flags", flags, 0);
        chk("R1 enables", en, 0);
        chk("R1 shorts", shorts, 0);
        chk("R1 errsrc", err, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tasks idle", tasks(), 0);

        // R3 enable write, set and clear ports
        wreg(3'd1, 7'h55); chk("R3 direct write", en, 7'h55);
        wreg(3'd2, 7'h0A); chk("R3 set port", en, 7'h5F);
        wreg(3'd3, 7'h41); chk("R3 clear port", en, 7'h1E);
        wreg(3'd1, 7'h00);

        // R2/R4 sweep: one flag against one enable
        for (int k = 0; k < 7; k++) begin
            for (int j = 0; j < 7; j++) begin
                wreg(3'd1, 7'(1 << j));
                pulse_ev(k);
                chk("R4 irq flag/enable match", irq, (k == j) ? 1 : 0);
                if (j == 0) begin
                    chk("R2 flag set", flags, 32'(1 << k));
                    repeat (3) cyc();
                    wreg(3'd4, 7'h7F);
                    chk("R2 sticky after write of ones", flags, 32'(1 << k));
                end
                wreg(3'd4, 7'h00);
                chk("R2 cleared by write of zero", flags, 0);
            end
        end
        wreg(3'd1, 7'h00);

        // R2 event wins over a clearing write in the same cycle
        wr = 1; addr = 3'd4; wdata = 7'h00; ev = 7'h08;
        cyc();
        wr = 0; ev = 0;
        chk("R2 event beats clear", flags, 7'h08);
        wreg(3'd4, 7'h00);

        // R5 shortcut sweep
        for (int s = 0; s < 5; s++) begin
            for (int e = 0; e < 2; e++) begin
                logic [4:0] exp;
                wreg(3'd0, 7'(e << s));
                chk("R5 shortcut readback", shorts, 32'(e << s));
                case (s)
                    0: exp = 5'b00010;
                    1: exp = 5'b01000;
                    2: exp = 5'b00100;
                    3: exp = 5'b00001;
                    default: exp = 5'b00100;
                endcase
                if (e == 0) exp = 0;
                ev = (s < 3) ? 7'h40 : 7'h20;
                #1;
                chk("R5 shortcut task pulse", tasks(), exp);
                cyc();
                ev = 0;
                s_res = 1;
                cyc();
                s_res = 0;
            end
        end
        wreg(3'd0, 7'h00);
        pulse_ev(0);
        wreg(3'd4, 7'h00);

        // R6 software tasks, R8 busy blocking
        s_tx = 1; #1; chk("R6 sw start tx", tasks(), 5'b00001); cyc(); s_tx = 0;
        s_rx = 1; #1; chk("R8 start while busy dropped", tasks(), 5'b00000); cyc(); s_rx = 0;
        s_stop = 1; #1; chk("R6 sw stop", tasks(), 5'b00100); cyc(); s_stop = 0;
        ev = 7'h01; s_rx = 1; #1;
        chk("R8 start with stopped event passes", tasks(), 5'b00010);
        cyc(); ev = 0; s_rx = 0;
        pulse_ev(0);
        s_susp = 1; #1; chk("R6 sw suspend", tasks(), 5'b01000); cyc(); s_susp = 0;
        s_res = 1; #1; chk("R6 sw resume", tasks(), 5'b10000); cyc(); s_res = 0;

        // R7 stop held across suspension
        s_susp = 1; cyc(); s_susp = 0;
        s_stop = 1; #1; chk("R7 stop held while suspended", t_stop, 0); cyc(); s_stop = 0;
        #1; chk("R7 no stop while still suspended", t_stop, 0);
        cyc();
        s_res = 1; #1; chk("R7 no stop in resume cycle", t_stop, 0); cyc(); s_res = 0;
        #1; chk("R7 stop one cycle after resume", t_stop, 1);
        cyc();
        #1; chk("R7 single released stop", t_stop, 0);

        // R9 error source
        ovr = 1; anack = 1; dnack = 1; cyc(); ovr = 0; anack = 0; dnack = 0;
        chk("R9 all errors latched", err, 3'h7);
        wreg(3'd5, 7'h02); chk("R9 anack cleared, overrun loaded 0", err, 3'h4);
        wreg(3'd5, 7'h04); chk("R9 dnack cleared", err, 3'h0);
        wreg(3'd5, 7'h01); chk("R9 overrun loaded 1", err, 3'h1);
        wreg(3'd5, 7'h00); chk("R9 overrun loaded 0", err, 3'h0);
        wreg(3'd4, 7'h00);

        // R10 write 2 then read 4 with auto repeated START and auto stop
        wreg(3'd0, 7'h11);
        s_tx = 1; #1; chk("R10 start tx", tasks(), 5'b00001); cyc(); s_tx = 0;
        pulse_ev(4);
        cyc();
        ev = 7'h40; #1; chk("R10 repeated start on last tx", tasks(), 5'b00010); cyc(); ev = 0;
        pulse_ev(3);
        repeat (3) begin
            #1; chk("R10 quiet during read", tasks(), 0); cyc();
        end
        ev = 7'h20; #1; chk("R10 stop on last rx", tasks(), 5'b00100); cyc(); ev = 0;
        pulse_ev(0);
        chk("R10 flags after sequence", flags, 7'h79);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule